// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Scan Controller

This block is the digital half of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. It derives a converter tick from the master clock, either every master cycle or every second one. For each channel it opens a fixed sample window and then resolves the code one bit per tick against a single comparator bit supplied by the analog front end. The finished code goes into that channel's own result register. The mux select, the sample enable and the trial DAC code leave the block as plain digital outputs.

A scan covers channels 0 through a programmable last channel. A rising edge on the start input launches it, provided power-down is low. In single mode the block stops after the last channel of the group. In continuous mode it returns to channel 0 and scans again for as long as start stays high. Dropping start or raising power-down stops the scan at once, and the channel being converted keeps its old result. Completing a group raises a maskable interrupt request that stays pending until cleared.

Top module: `adc_scan_ctrl`

## Requirements
- R1: With `cfg_clk_half` low the converter ticks on every master clock; with it high, on every second master clock, so a scan of N channels lasts 82·N cycles or 164·N cycles (±1) respectively.
- R2: Every conversion lasts exactly 82 ticks, and `sample_en` is high for the first 51 of them. Launched with `cfg_clk_half` low, a group of N channels keeps `conv_busy` high for 82·N cycles.
- R3: Bits are resolved MSB first, one per tick. A trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`) and dropped otherwise. The stored code is the input value, and any input at or above full scale stores 8'hFF with no overflow indication.
- R4: Channels are converted in ascending order from 0 to `cfg_last_ch`. Channel c's result sits in `result_flat[8c+7:8c]`, and channels above the last keep their previous values.
- R5: In single mode (`cfg_continuous` = 0) a rising edge of `cfg_start` launches one scan. The block goes idle after the group and does not relaunch while start stays high.
- R6: In continuous mode the scan returns to channel 0 straight after the last channel, with no idle cycle. The interrupt is raised after every pass.
- R7: While `cfg_power_down` is high no scan launches, and raising it during a scan stops the scan on the next cycle without writing a result.
- R8: Lowering `cfg_start` during a scan stops it on the next cycle, and the channel in progress keeps its old result.
- R9: `irq` is set in the cycle the last channel of a group is stored. It stays set until a one on `irq_clear` arrives. While `irq_en` is low, `irq` is held at 0 and no request is kept.
- R10: After reset all results are 0, and `irq`, `conv_busy`, `sample_en`, `mux_sel` and `dac_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start level; its rising edge launches a scan, and its low level stops one |
| cfg_continuous | input | 1 | 1 = rescan from channel 0 indefinitely, 0 = one pass |
| cfg_power_down | input | 1 | Holds the converter idle |
| cfg_clk_half | input | 1 | Converter tick at half the master rate |
| cfg_last_ch | input | 3 | Index of the last channel of the group |
| irq_en | input | 1 | Interrupt mask (1 = enabled) |
| irq_clear | input | 1 | Write-one-to-clear of the pending request |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| sample_en | output | 1 | Sample-and-hold window |
| dac_code | output | 8 | Current trial code for the DAC |
| mux_sel | output | 3 | Channel select (0 when idle) |
| conv_busy | output | 1 | A scan is running |
| result_flat | output | 64 | Eight per-channel results, channel c at bits 8c+7:8c |
| irq | output | 1 | Pending end-of-conversion request |

## Verification
Inputs change on falling edges, and the launch happens at the next rising edge. With the tick at full rate, `conv_busy` falls, `irq` rises and the last result is written on the falling edge 82·N+1 after start was raised. At half rate the same point lies within 164·N to 164·N+2. The bench counts falling edges from the start request until `conv_busy` drops, compares that count with these windows, and compares every channel's result with the saturated input value at that edge. The bench counts the sample-window and channel-select cycles along the way. After a stop, mask or clear request, the bench looks one falling edge later and again some hundreds of cycles later to confirm that nothing restarted.

// File: rtl/adc_scan_pkg.sv
// Shared constants and types for the scan controller.
// Assumes: the trial window (SAMPLE_TICKS + ADC_BITS) fits inside CONV_TICKS.
package adc_scan_pkg;
    localparam int unsigned ADC_BITS     = 8;
    localparam int unsigned ADC_CHANNELS = 8;
    localparam int unsigned SAMPLE_TICKS = 51;
    localparam int unsigned CONV_TICKS   = 82;

    // Phase of one channel conversion, decoded from the tick counter.
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_TRIAL  = 2'd1,
        PH_TAIL   = 2'd2
    } conv_phase_t;
endpackage

// File: rtl/adc_tick_gen.sv
// Converter tick generator: a tick on every master clock or on every second one.
// Assumes: the halving select may change at any time; the phase is free-running.
module adc_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic half,
    output logic tick
);
    logic toggle;

    // Free-running divide-by-two phase.
    always_ff @(posedge clk) begin
        if (!rst_n) toggle <= 1'b0;
        else        toggle <= ~toggle;
    end

    // Select full-rate or halved tick.
    assign tick = half ? toggle : 1'b1;
endmodule

// File: rtl/adc_sar_core.sv
// One channel conversion: a sample window, then MSB-first bit trials, then a tail
// that pads the conversion to a fixed tick count. conv_done pulses on the final tick.
// Assumes: abort has priority over launch; restart is sampled on the final tick.
module adc_sar_core
    import adc_scan_pkg::*;
#(
    parameter int BITS   = ADC_BITS,
    parameter int SAMPLE = SAMPLE_TICKS,
    parameter int TOTAL  = CONV_TICKS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            launch,
    input  logic            abort,
    input  logic            restart,
    input  logic            cmp_in,
    output logic            busy,
    output logic            sample_en,
    output logic            conv_done,
    output logic [BITS-1:0] code
);
    localparam int CW        = $clog2(TOTAL);
    localparam int TRIAL_END = SAMPLE + BITS - 1;

    logic [CW-1:0]   cnt;
    logic [BITS-1:0] approx, approx_nxt;
    conv_phase_t     phase;
    int              trial_idx;

    // Decode the conversion phase from the tick counter.
    always_comb begin
        if (int'(cnt) < SAMPLE)          phase = PH_SAMPLE;
        else if (int'(cnt) <= TRIAL_END) phase = PH_TRIAL;
        else                             phase = PH_TAIL;
    end

    assign trial_idx = BITS - 1 - (int'(cnt) - SAMPLE);

    // Next approximation: seed the MSB trial, then keep or drop each bit and try the next.
    always_comb begin
        approx_nxt = approx;
        if (int'(cnt) == SAMPLE - 1) begin
            approx_nxt = '0;
            approx_nxt[BITS-1] = 1'b1;
        end else if (phase == PH_TRIAL) begin
            for (int b = 0; b < BITS; b++) begin
                if (b == trial_idx && !cmp_in) approx_nxt[b] = 1'b0;
            end
            for (int b = 1; b < BITS; b++) begin
                if (b == trial_idx) approx_nxt[b-1] = 1'b1;
            end
        end
    end

    assign conv_done = busy && tick && !abort && (cnt == CW'(TOTAL - 1));
    assign sample_en = busy && (phase == PH_SAMPLE);
    assign code      = approx;

    // Tick counter, busy flag and approximation register.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy   <= 1'b0;
            cnt    <= '0;
            approx <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            cnt    <= '0;
            approx <= '0;
        end else if (busy && tick) begin
            if (cnt == CW'(TOTAL - 1)) begin
                cnt    <= '0;
                approx <= '0;
                busy   <= restart;
            end else begin
                cnt    <= cnt + 1'b1;
                approx <= approx_nxt;
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result registers, flattened onto one output vector.
// Assumes: at most one write per cycle, addressed by wr_ch.
module adc_result_bank
    import adc_scan_pkg::*;
#(
    parameter int BITS     = ADC_BITS,
    parameter int CHANNELS = ADC_CHANNELS,
    localparam int CHW     = $clog2(CHANNELS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic [BITS-1:0]          wr_data,
    output logic [CHANNELS*BITS-1:0] results
);
    for (genvar g = 0; g < CHANNELS; g++) begin : g_reg
        // Store the finished code of channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                results[g*BITS +: BITS] <= '0;
            else if (wr_en && wr_ch == CHW'(g))
                results[g*BITS +: BITS] <= wr_data;
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan controller top: launches on a rising start, walks channels 0..last,
// stores each code in its channel's register and raises a maskable group-end request.
// Assumes: cmp_in settles within one master clock of a dac_code change.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int BITS     = ADC_BITS,
    parameter int CHANNELS = ADC_CHANNELS,
    parameter int SAMPLE   = SAMPLE_TICKS,
    parameter int TOTAL    = CONV_TICKS,
    localparam int CHW     = $clog2(CHANNELS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_start,
    input  logic                     cfg_continuous,
    input  logic                     cfg_power_down,
    input  logic                     cfg_clk_half,
    input  logic [CHW-1:0]           cfg_last_ch,
    input  logic                     irq_en,
    input  logic                     irq_clear,
    input  logic                     cmp_in,
    output logic                     sample_en,
    output logic [BITS-1:0]          dac_code,
    output logic [CHW-1:0]           mux_sel,
    output logic                     conv_busy,
    output logic [CHANNELS*BITS-1:0] result_flat,
    output logic                     irq
);
    logic           tick, start_q, launch, abort, restart, conv_done, group_end;
    logic [CHW-1:0] ch;

    adc_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .half  (cfg_clk_half),
        .tick  (tick)
    );

    assign launch    = cfg_start && !start_q && !cfg_power_down && !conv_busy;
    assign abort     = conv_busy && (!cfg_start || cfg_power_down);
    assign group_end = (ch >= cfg_last_ch);
    assign restart   = cfg_continuous || !group_end;

    adc_sar_core #(.BITS(BITS), .SAMPLE(SAMPLE), .TOTAL(TOTAL)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .launch    (launch),
        .abort     (abort),
        .restart   (restart),
        .cmp_in    (cmp_in),
        .busy      (conv_busy),
        .sample_en (sample_en),
        .conv_done (conv_done),
        .code      (dac_code)
    );

    adc_result_bank #(.BITS(BITS), .CHANNELS(CHANNELS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (conv_done),
        .wr_ch   (ch),
        .wr_data (dac_code),
        .results (result_flat)
    );

    // Remember start for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= cfg_start;
    end

    // Channel pointer: reset on launch, advance or wrap on each finished channel.
    always_ff @(posedge clk) begin
        if (!rst_n || launch)  ch <= '0;
        else if (conv_done)    ch <= group_end ? '0 : ch + 1'b1;
    end

    // Pending request: masked away, set at group end, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n || !irq_en)         irq <= 1'b0;
        else if (conv_done && group_end) irq <= 1'b1;
        else if (irq_clear)            irq <= 1'b0;
    end

    assign mux_sel = conv_busy ? ch : '0;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
// Temporal checks on the scan controller ports, attached by bind below.
// Assumes: the same parameters as the instance it is bound to.
module adc_scan_ctrl_chk
    import adc_scan_pkg::*;
#(
    parameter int BITS     = ADC_BITS,
    parameter int CHANNELS = ADC_CHANNELS,
    localparam int CHW     = $clog2(CHANNELS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_start,
    input logic                     cfg_power_down,
    input logic                     irq_en,
    input logic                     irq_clear,
    input logic                     sample_en,
    input logic [BITS-1:0]          dac_code,
    input logic [CHW-1:0]           mux_sel,
    input logic                     conv_busy,
    input logic [CHANNELS*BITS-1:0] result_flat,
    input logic                     irq
);
    a_r7_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_power_down |=> !conv_busy);

    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start |=> !conv_busy);

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    a_r9_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(irq_clear) || !$past(irq_en)));

    a_r2_mux_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(sample_en)) |-> $stable(mux_sel));

    a_r4_results_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && ($past(conv_busy) == 1'b0)) |-> $stable(result_flat));

    a_r3_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_busy |-> (dac_code == '0));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.BITS(BITS), .CHANNELS(CHANNELS)) u_chk (.*);

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
    localparam int BITS = 8;
    localparam int NCH  = 8;
    localparam int CONV = 82;
    localparam int SAMP = 51;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, cfg_start, cfg_continuous, cfg_power_down, cfg_clk_half;
    logic [2:0]        cfg_last_ch, mux_sel;
    logic              irq_en, irq_clear, cmp_in, sample_en, conv_busy, irq;
    logic [BITS-1:0]   dac_code;
    logic [NCH*BITS-1:0] result_flat;

    logic [8:0] ain [NCH];
    logic [7:0] model [NCH];
    int checks = 0;
    int errors = 0;

    // Comparator model: input at or above the trial code.
    assign cmp_in = (ain[mux_sel] >= {1'b0, dac_code});

    adc_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_continuous(cfg_continuous),
        .cfg_power_down(cfg_power_down), .cfg_clk_half(cfg_clk_half), .cfg_last_ch(cfg_last_ch),
        .irq_en(irq_en), .irq_clear(irq_clear), .cmp_in(cmp_in), .sample_en(sample_en),
        .dac_code(dac_code), .mux_sel(mux_sel), .conv_busy(conv_busy),
        .result_flat(result_flat), .irq(irq)
    );

    function automatic logic [7:0] sat8(logic [8:0] v);
        return (v > 9'd255) ? 8'hFF : v[7:0];
    endfunction

    function automatic logic [7:0] res_of(int c);
        return result_flat[c*BITS +: BITS];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_results(input string tag);
        for (int c = 0; c < NCH; c++)
            chk(res_of(c) == model[c], tag, res_of(c), model[c]);
    endtask

    // One single-mode scan; timing, order and results checked at the ports.
    task automatic scan_single(input int last, input bit half, input bit do_clear);
        int n = 0, s = 0, mm = 0, nch = last + 1;
        @(negedge clk);
        cfg_last_ch = 3'(last); cfg_clk_half = half; cfg_continuous = 1'b0; cfg_start = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (sample_en) s++;
            if (conv_busy && !half && int'(mux_sel) != (n - 1) / CONV) mm++;
        end while (conv_busy && n < 5000);
        if (!half) begin
            chk(n == CONV * nch + 1, "R2 scan length", n, CONV * nch + 1);
            chk(s == SAMP * nch, "R2 sample window", s, SAMP * nch);
            chk(mm == 0, "R4 channel order", mm, 0);
        end else begin
            chk(n >= 2 * CONV * nch && n <= 2 * CONV * nch + 2, "R1 halved tick", n, 2 * CONV * nch + 1);
        end
        chk(irq == irq_en, "R9 group-end request", irq, irq_en);
        for (int c = 0; c <= last; c++) model[c] = sat8(ain[c]);
        check_results("R3 R4 stored codes");
        repeat (4) @(negedge clk);
        chk(!conv_busy, "R5 single mode stays idle", conv_busy, 0);
        cfg_start = 1'b0;
        if (do_clear) begin
            irq_clear = 1'b1;
            @(negedge clk);
            irq_clear = 1'b0;
            chk(!irq, "R9 write-one clear", irq, 0);
        end
    endtask

    // Start a full scan on fresh inputs, then stop it early by power-down or start low.
    task automatic abort_scan(input bit by_pd, input int after);
        for (int c = 0; c < NCH; c++) ain[c] = {1'b0, ~model[c]};
        @(negedge clk);
        cfg_last_ch = 3'd7; cfg_clk_half = 1'b0; cfg_continuous = 1'b0; cfg_start = 1'b1;
        repeat (after) @(negedge clk);
        if (by_pd) cfg_power_down = 1'b1; else cfg_start = 1'b0;
        @(negedge clk);
        chk(!conv_busy, by_pd ? "R7 power-down stops" : "R8 start low stops", conv_busy, 0);
        repeat (300) @(negedge clk);
        chk(!conv_busy, by_pd ? "R7 no restart" : "R8 no restart", conv_busy, 0);
        check_results(by_pd ? "R7 results kept" : "R8 results kept");
        chk(!irq, "R8 no request after stop", irq, 0);
        cfg_power_down = 1'b0; cfg_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R5 actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, busy_seen;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_start = 0; cfg_continuous = 0; cfg_power_down = 0; cfg_clk_half = 0;
        cfg_last_ch = 0; irq_en = 0; irq_clear = 0;
        for (int c = 0; c < NCH; c++) begin ain[c] = 9'd0; model[c] = 8'd0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!irq, "R10 irq", irq, 0);
        chk(!conv_busy, "R10 busy", conv_busy, 0);
        chk(!sample_en, "R10 sample", sample_en, 0);
        chk(mux_sel == 0, "R10 mux", mux_sel, 0);
        chk(dac_code == 0, "R10 dac", dac_code, 0);
        check_results("R10 results zero");

        irq_en = 1'b1;
        // R3 saturation: every input above full scale
        for (int c = 0; c < NCH; c++) ain[c] = 9'd300;
        scan_single(7, 1'b0, 1'b1);
        // R3 exact full scale and zero, R4 upper channels untouched
        ain[0] = 9'd0; ain[1] = 9'd255; ain[2] = 9'd128; ain[3] = 9'd127;
        scan_single(3, 1'b0, 1'b1);
        ain[0] = 9'd1;
        scan_single(0, 1'b1, 1'b1);

        // Random scans
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < NCH; c++) ain[c] = 9'($urandom_range(0, 300));
            scan_single($urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'b1);
        end

        // R9 mask: no request while disabled, and masking drops a pending one
        irq_en = 1'b0;
        for (int c = 0; c < NCH; c++) ain[c] = 9'($urandom_range(0, 255));
        scan_single(2, 1'b0, 1'b0);
        irq_en = 1'b1;
        scan_single(1, 1'b0, 1'b0);
        chk(irq, "R9 request pending", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk(!irq, "R9 mask clears", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(!irq, "R9 request discarded", irq, 0);

        // R7 power-down blocks a launch
        cfg_power_down = 1'b1;
        @(negedge clk);
        cfg_start = 1'b1;
        busy_seen = 0;
        repeat (200) begin @(negedge clk); if (conv_busy) busy_seen++; end
        chk(busy_seen == 0, "R7 no launch in power-down", busy_seen, 0);
        cfg_power_down = 1'b0; cfg_start = 1'b0;
        @(negedge clk);

        abort_scan(1'b1, 40);
        abort_scan(1'b0, 60);

        // R6 continuous mode
        for (int c = 0; c < NCH; c++) ain[c] = 9'($urandom_range(0, 300));
        @(negedge clk);
        cfg_last_ch = 3'd2; cfg_continuous = 1'b1; cfg_start = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 2000);
        chk(n == 3 * CONV + 1, "R6 first pass length", n, 3 * CONV + 1);
        for (int c = 0; c < 3; c++) model[c] = sat8(ain[c]);
        check_results("R6 first pass results");
        chk(conv_busy && mux_sel == 0, "R6 rescan from channel 0", mux_sel, 0);
        irq_clear = 1'b1;
        for (int c = 0; c < 3; c++) ain[c] = 9'($urandom_range(0, 255));
        @(negedge clk);
        irq_clear = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 2000);
        chk(n == 3 * CONV - 1, "R6 second pass length", n, 3 * CONV - 1);
        for (int c = 0; c < 3; c++) model[c] = sat8(ain[c]);
        check_results("R6 second pass results");
        cfg_start = 1'b0; cfg_continuous = 1'b0;
        @(negedge clk);
        chk(!conv_busy, "R8 continuous stop", conv_busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule